// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words in the common single-precision layout: a sign bit in bit 31 (1 means negative), an 8-bit exponent field in bits 30:23 stored with an offset of 127, and a 23-bit fraction in bits 22:0 that sits below an implicit leading one. A request is presented as two operands and a one-cycle `in_valid` strobe. The block then walks a fixed sequence of four working steps and returns the sum with a one-cycle `out_valid` strobe and two range flags.

The control is a five-state machine. `S_IDLE` waits for a request and, on `in_valid`, unpacks both words, flushes subnormal inputs to zero, resolves NaN and infinity inputs, and orders the operands by magnitude (transition IDLE→ALIGN). `S_ALIGN` shifts the smaller significand right by the exponent gap and keeps guard, round and sticky bits (ALIGN→ADD). `S_ADD` adds or subtracts the aligned significands according to the operand signs (ADD→NORM). `S_NORM` brings the leading one back to its place and checks the exponent range (NORM→ROUND). `S_ROUND` rounds to nearest with ties to even, performs a second normalization when rounding carries out, and emits the result (ROUND→IDLE). No other transitions exist, and a request is only taken in `S_IDLE`.

Top module: `fpa_adder`

## Requirements
- R1: For normal operands whose exact sum is a normal number, `result` is the sum rounded to nearest, ties to even, and both flags stay 0 (for example 0x3F800000 + 0x3F800000 gives 0x40000000, and 0x3FC00000 + 0x40100000 gives 0x40700000 in either operand order).
- R2: When the signs differ, the smaller operand is aligned and subtracted and the difference is normalized by a left shift with a matching exponent decrease (0x3F000000 + 0xBEE00000 gives 0x3D800000).
- R3: Rounding uses the bits below the kept fraction: an exact half-way case rounds to the even fraction, and any nonzero bit beyond the round position counts toward rounding up.
- R4: When rounding carries out of the significand, the result is renormalized to fraction 0 with the exponent incremented (0x3FFFFFFF + 0x33800000 gives 0x40000000).
- R5: A result exponent field of 255 or more, whether reached before or after rounding, yields sign-preserving infinity (exponent field 0xFF, fraction 0) with `overflow` = 1; `overflow` and `underflow` are never both 1.
- R6: A nonzero result whose exponent field would be 0 or below yields a zero carrying the result sign with `underflow` = 1.
- R7: An exact zero sum of finite operands yields +0 (0x00000000) with both flags 0.
- R8: An input whose exponent field is 0 is treated as zero, whatever its fraction bits.
- R9: If either input has exponent field 0xFF and a nonzero fraction, or the inputs are infinities of opposite sign, the result is 0x7FC00000; otherwise an infinity input yields infinity of its own sign; flags stay 0 in these cases.
- R10: `out_valid` rises 5 clock cycles after the edge that accepts `in_valid` (the accepting edge counts as the first), lasts exactly one cycle, and the flags are 1 only while `out_valid` is 1.
- R11: `in_valid` asserted while a sum is in progress is ignored: it neither alters the pending result nor starts another computation.
- R12: During reset `out_valid`, `overflow`, `underflow` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, taken only when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 32 | Rounded sum, held until the next result |
| overflow | output | 1 | Result saturated to infinity |
| underflow | output | 1 | Result flushed to zero |

## Verification
The bench aims at the rounding boundary: exact ties with an even and an odd kept fraction, a tie broken by a distant sticky bit, and an all-ones significand whose round-up must renormalize; a design that truncates, rounds ties away from zero or drops the sticky bit returns a neighbouring word, and one that skips the second normalization returns a doubled exponent-less fraction. It drives heavy cancellation and the smallest-normal subtraction, where a wrong leading-zero count gives a wrong exponent and a missing range check gives a garbage subnormal pattern instead of a flagged signed zero. Overflow is reached both directly and only through rounding, so a design that checks the range once misses the second. Special inputs, subnormal inputs, operand order and requests during a busy period are also driven, where a faulty design would leak payloads, add subnormal fractions or let a second request overwrite the first.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Control sequence of the adder.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ALIGN = 3'd1,
        S_ADD   = 3'd2,
        S_NORM  = 3'd3,
        S_ROUND = 3'd4
    } fpa_state_e;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_f,
    output logic [FRAC_W:0]       sig,
    output logic                  is_inf,
    output logic                  is_nan
);
    logic [EXP_W-1:0]  raw_exp;
    logic [FRAC_W-1:0] raw_frac;
    logic              flushed;
    logic              exp_full;

    assign sign     = word[EXP_W+FRAC_W];
    assign raw_exp  = word[EXP_W+FRAC_W-1:FRAC_W];
    assign raw_frac = word[FRAC_W-1:0];
    assign flushed  = (raw_exp == '0);
    assign exp_full = (raw_exp == '1);
    assign is_inf   = exp_full && (raw_frac == '0);
    assign is_nan   = exp_full && (raw_frac != '0);

    // Subnormals become zero: exponent 0, empty significand.
    assign exp_f = flushed ? '0 : raw_exp;
    assign sig   = flushed ? '0 : {1'b1, raw_frac};
endmodule

// File: rtl/fpa_rshift_sticky.sv
module fpa_rshift_sticky #(
    parameter int W  = 27,
    parameter int SW = 8
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] lost_mask;

    always_comb begin
        lost_mask = ~({W{1'b1}} << amt);
        if (int'(amt) >= W) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            dout    = din >> amt;
            dout[0] = dout[0] | (|(din & lost_mask));
        end
    end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
    parameter int W  = 27,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] count
);
    logic found;

    always_comb begin
        count = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && din[i]) begin
                count = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpa_round_rne.sv
module fpa_round_rne #(
    parameter int MW = 24
) (
    input  logic [MW+2:0] din,
    output logic [MW-2:0] frac_o,
    output logic          carry_o
);
    logic [MW-1:0] kept;
    logic          g_bit;
    logic          r_bit;
    logic          s_bit;
    logic          bump;
    logic [MW:0]   inc;

    assign kept  = din[MW+2:3];
    assign g_bit = din[2];
    assign r_bit = din[1];
    assign s_bit = din[0];
    assign bump  = g_bit && (r_bit || s_bit || kept[0]);
    assign inc   = {1'b0, kept} + {{MW{1'b0}}, bump};

    assign carry_o = inc[MW];
    // After a carry-out the significand is 1.000..0 one position higher.
    assign frac_o  = carry_o ? inc[MW-1:1] : inc[MW-2:0];
endmodule

// File: rtl/fpa_adder.sv
module fpa_adder #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  overflow,
    output logic                  underflow
);
    import fpa_pkg::*;

    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int SUM_W = EXT_W + 1;
    localparam int EV_W  = EXP_W + 2;
    localparam int LZ_W  = $clog2(EXT_W + 1);

    localparam logic [EXP_W-1:0]       EXP_ONES = '1;
    localparam logic signed [EV_W-1:0] EMAX_S   = $signed({2'b00, EXP_ONES});
    localparam logic signed [EV_W-1:0] EONE_S   = 1;
    localparam logic [W-1:0]           NAN_WORD = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    fpa_state_e state;
    fpa_state_e state_nx;

    // ---------------- unpack and special-case resolution ----------------
    logic              a_sign, b_sign;
    logic [EXP_W-1:0]  a_exp, b_exp;
    logic [SIG_W-1:0]  a_sig, b_sig;
    logic              a_inf, b_inf, a_nan, b_nan;
    logic              a_is_big;
    logic              spec_hit;
    logic [W-1:0]      spec_word;

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word(op_a), .sign(a_sign), .exp_f(a_exp), .sig(a_sig),
        .is_inf(a_inf), .is_nan(a_nan)
    );

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word(op_b), .sign(b_sign), .exp_f(b_exp), .sig(b_sig),
        .is_inf(b_inf), .is_nan(b_nan)
    );

    assign a_is_big = ({a_exp, a_sig} >= {b_exp, b_sig});

    always_comb begin
        spec_hit  = 1'b0;
        spec_word = '0;
        if (a_nan || b_nan) begin
            spec_hit  = 1'b1;
            spec_word = NAN_WORD;
        end else if (a_inf && b_inf) begin
            spec_hit  = 1'b1;
            spec_word = (a_sign != b_sign) ? NAN_WORD
                                           : {a_sign, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (a_inf) begin
            spec_hit  = 1'b1;
            spec_word = {a_sign, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (b_inf) begin
            spec_hit  = 1'b1;
            spec_word = {b_sign, EXP_ONES, {FRAC_W{1'b0}}};
        end
    end

    // ---------------- captured operands ----------------
    logic              big_sign_q;
    logic [EXP_W-1:0]  big_exp_q, sml_exp_q;
    logic [SIG_W-1:0]  big_sig_q, sml_sig_q;
    logic              eff_sub_q;
    logic              spec_q;
    logic [W-1:0]      spec_word_q;

    // ---------------- step 1: alignment ----------------
    logic [EXP_W-1:0]  exp_gap;
    logic [EXT_W-1:0]  sml_shifted;
    logic [EXT_W-1:0]  big_ext_q, sml_ext_q;

    assign exp_gap = big_exp_q - sml_exp_q;

    fpa_rshift_sticky #(.W(EXT_W), .SW(EXP_W)) u_align (
        .din ({sml_sig_q, 3'b000}),
        .amt (exp_gap),
        .dout(sml_shifted)
    );

    // ---------------- step 2: significand add ----------------
    logic [SUM_W-1:0]  sum_comb;
    logic [SUM_W-1:0]  sum_q;

    assign sum_comb = eff_sub_q ? ({1'b0, big_ext_q} - {1'b0, sml_ext_q})
                                : ({1'b0, big_ext_q} + {1'b0, sml_ext_q});

    // ---------------- step 3: normalization and range check ----------------
    logic [LZ_W-1:0]          lead_zeros;
    logic [EXT_W-1:0]         n_sig;
    logic signed [EV_W-1:0]   n_exp;
    logic signed [EV_W-1:0]   big_exp_s;
    logic                     n_zero;
    logic [EXT_W-1:0]         norm_q;
    logic signed [EV_W-1:0]   nexp_q;
    logic                     nzero_q, novf_q, nunf_q;

    fpa_lzc #(.W(EXT_W), .CW(LZ_W)) u_lzc (
        .din  (sum_q[EXT_W-1:0]),
        .count(lead_zeros)
    );

    assign big_exp_s = $signed({2'b00, big_exp_q});
    assign n_zero    = (sum_q == '0);

    always_comb begin
        if (sum_q[SUM_W-1]) begin
            n_sig = {sum_q[SUM_W-1:2], |sum_q[1:0]};
            n_exp = big_exp_s + EONE_S;
        end else begin
            n_sig = sum_q[EXT_W-1:0] << lead_zeros;
            n_exp = big_exp_s - $signed({{(EV_W-LZ_W){1'b0}}, lead_zeros});
        end
    end

    // ---------------- step 4: rounding and second normalization ----------------
    logic [FRAC_W-1:0]        r_frac;
    logic                     r_carry;
    logic signed [EV_W-1:0]   r_exp;
    logic [W-1:0]             fin_word;
    logic                     fin_ovf, fin_unf;

    fpa_round_rne #(.MW(SIG_W)) u_round (
        .din    (norm_q),
        .frac_o (r_frac),
        .carry_o(r_carry)
    );

    assign r_exp = nexp_q + $signed({{(EV_W-1){1'b0}}, r_carry});

    always_comb begin
        fin_ovf  = 1'b0;
        fin_unf  = 1'b0;
        fin_word = '0;
        if (spec_q) begin
            fin_word = spec_word_q;
        end else if (nzero_q) begin
            fin_word = '0;
        end else if (novf_q || (r_exp >= EMAX_S)) begin
            fin_ovf  = 1'b1;
            fin_word = {big_sign_q, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (nunf_q) begin
            fin_unf  = 1'b1;
            fin_word = {big_sign_q, {(W-1){1'b0}}};
        end else begin
            fin_word = {big_sign_q, r_exp[EXP_W-1:0], r_frac};
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nx = S_ALIGN;
            S_ALIGN: state_nx = S_ADD;
            S_ADD:   state_nx = S_NORM;
            S_NORM:  state_nx = S_ROUND;
            S_ROUND: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_sign_q  <= 1'b0;
            big_exp_q   <= '0;
            sml_exp_q   <= '0;
            big_sig_q   <= '0;
            sml_sig_q   <= '0;
            eff_sub_q   <= 1'b0;
            spec_q      <= 1'b0;
            spec_word_q <= '0;
            big_ext_q   <= '0;
            sml_ext_q   <= '0;
            sum_q       <= '0;
            norm_q      <= '0;
            nexp_q      <= '0;
            nzero_q     <= 1'b0;
            novf_q      <= 1'b0;
            nunf_q      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        big_sign_q  <= a_is_big ? a_sign : b_sign;
                        big_exp_q   <= a_is_big ? a_exp  : b_exp;
                        big_sig_q   <= a_is_big ? a_sig  : b_sig;
                        sml_exp_q   <= a_is_big ? b_exp  : a_exp;
                        sml_sig_q   <= a_is_big ? b_sig  : a_sig;
                        eff_sub_q   <= a_sign ^ b_sign;
                        spec_q      <= spec_hit;
                        spec_word_q <= spec_word;
                    end
                end
                S_ALIGN: begin
                    big_ext_q <= {big_sig_q, 3'b000};
                    sml_ext_q <= sml_shifted;
                end
                S_ADD: begin
                    sum_q <= sum_comb;
                end
                S_NORM: begin
                    norm_q  <= n_sig;
                    nexp_q  <= n_exp;
                    nzero_q <= n_zero;
                    novf_q  <= !n_zero && (n_exp >= EMAX_S);
                    nunf_q  <= !n_zero && (n_exp < EONE_S);
                end
                S_ROUND: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (state == S_ROUND) begin
            out_valid <= 1'b1;
            result    <= fin_word;
            overflow  <= fin_ovf;
            underflow <= fin_unf;
        end else begin
            out_valid <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end
    end

endmodule

// File: rtl/fpa_adder_chk.sv
module fpa_adder_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  overflow,
    input logic                  underflow
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-2:0] MAG_INF = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [W-1:0] NAN_W   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5)); // R10

    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |-> out_valid); // R10

    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result[W-2:0] == MAG_INF)); // R5

    AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow)); // R5

    AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (result[W-2:0] == '0)); // R6

    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (result[W-2:FRAC_W] == '1) && (result[FRAC_W-1:0] != '0))
        |-> (result == NAN_W)); // R9

endmodule

bind fpa_adder fpa_adder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .result   (result),
    .overflow (overflow),
    .underflow(underflow)
);

// File: tb/sim_fpa_adder.sv
module sim_fpa_adder;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        overflow;
    logic        underflow;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    fpa_adder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .result(result), .overflow(overflow), .underflow(underflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Drive one request, wait for its strobe, check word, flags and timing.
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_r, input logic exp_o, input logic exp_u);
        int lat;
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(req, "result", result, exp_r);
        check(req, "overflow", {31'd0, overflow}, {31'd0, exp_o});
        check(req, "underflow", {31'd0, underflow}, {31'd0, exp_u});
        check("R10", "latency", 32'(lat), 32'(LATENCY));
        @(negedge clk);
        check("R10", "strobe width", {31'd0, out_valid}, 32'd0);
        check("R10", "flags after strobe", {30'd0, overflow, underflow}, 32'd0);
    endtask

    task automatic t_reset;
        check("R12", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R12", "result in reset", result, 32'h0);
        check("R12", "flags in reset", {30'd0, overflow, underflow}, 32'd0);
    endtask

    task automatic t_basic;   // R1
        run_op("R1", 32'h3F800000, 32'h3F800000, 32'h40000000, 1'b0, 1'b0);
        run_op("R1", 32'h3FC00000, 32'h40100000, 32'h40700000, 1'b0, 1'b0);
        run_op("R1", 32'h40100000, 32'h3FC00000, 32'h40700000, 1'b0, 1'b0);
        run_op("R1", 32'hBFC00000, 32'hC0100000, 32'hC0700000, 1'b0, 1'b0);
    endtask

    task automatic t_cancel;  // R2
        run_op("R2", 32'h3F000000, 32'hBEE00000, 32'h3D800000, 1'b0, 1'b0);
        run_op("R2", 32'h3F800000, 32'hC0000000, 32'hBF800000, 1'b0, 1'b0);
        run_op("R2", 32'h3F800000, 32'h80800000, 32'h3F800000, 1'b0, 1'b0);
    endtask

    task automatic t_ties;    // R3
        run_op("R3", 32'h3F800000, 32'h33800000, 32'h3F800000, 1'b0, 1'b0);
        run_op("R3", 32'h3F800001, 32'h33800000, 32'h3F800002, 1'b0, 1'b0);
        run_op("R3", 32'h3F800000, 32'h33800001, 32'h3F800001, 1'b0, 1'b0);
        run_op("R3", 32'h3F800000, 32'h00800000, 32'h3F800000, 1'b0, 1'b0);
    endtask

    task automatic t_carry;   // R4
        run_op("R4", 32'h3FFFFFFF, 32'h33800000, 32'h40000000, 1'b0, 1'b0);
    endtask

    task automatic t_overflow; // R5
        run_op("R5", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1'b1, 1'b0);
        run_op("R5", 32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 1'b1, 1'b0);
        run_op("R5", 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1'b1, 1'b0);
    endtask

    task automatic t_underflow; // R6
        run_op("R6", 32'h00800000, 32'h80C00000, 32'h80000000, 1'b0, 1'b1);
        run_op("R6", 32'h80800000, 32'h00C00000, 32'h00000000, 1'b0, 1'b1);
    endtask

    task automatic t_zero;    // R7
        run_op("R7", 32'h3F800000, 32'hBF800000, 32'h00000000, 1'b0, 1'b0);
        run_op("R7", 32'hC0000000, 32'h40000000, 32'h00000000, 1'b0, 1'b0);
    endtask

    task automatic t_denorm;  // R8
        run_op("R8", 32'h00000001, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0);
        run_op("R8", 32'h3F800000, 32'h807FFFFF, 32'h3F800000, 1'b0, 1'b0);
        run_op("R8", 32'h00400000, 32'h00400000, 32'h00000000, 1'b0, 1'b0);
    endtask

    task automatic t_special; // R9
        run_op("R9", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0);
        run_op("R9", 32'h3F800000, 32'hFFC12345, 32'h7FC00000, 1'b0, 1'b0);
        run_op("R9", 32'h7F800000, 32'h3F800000, 32'h7F800000, 1'b0, 1'b0);
        run_op("R9", 32'h3F800000, 32'hFF800000, 32'hFF800000, 1'b0, 1'b0);
        run_op("R9", 32'h7F800000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0);
        run_op("R9", 32'hFF800000, 32'hFF800000, 32'hFF800000, 1'b0, 1'b0);
    endtask

    task automatic t_busy;    // R11
        int lat;
        int extra;
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h3F800000; in_valid = 1'b1;
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h40000000;   // would give 0x40400000
        lat = 1;
        repeat (2) begin
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R11", "first request kept", result, 32'h40000000);
        check("R11", "latency under busy requests", 32'(lat), 32'(LATENCY));
        extra = 0;
        repeat (8) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        check("R11", "no extra result from busy request", 32'(extra), 32'd0);
        check("R11", "result held", result, 32'h40000000);
        run_op("R11", 32'h3F800000, 32'h40000000, 32'h40400000, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_cancel();
        t_ties();
        t_carry();
        t_overflow();
        t_underflow();
        t_zero();
        t_denorm();
        t_special();
        t_busy();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule